// File: doc/BRIEF.md
# Two-Way Latched/Registered Bus Transceiver

This block moves a data word between two ports, A and B, in both directions at once. Each direction has its own storage element and its own three controls: a latch enable, a capture clock and a drive enable. The storage element works in one of three ways. While the latch enable is high it is transparent, so the opposite port follows the source port in the same cycle. While the latch enable is low it holds its value. It captures a new value when its capture clock rises while the latch enable is low.

Each port's three-state pad is modelled as three separate signals: data in, data out and output enable. This keeps every net one-directional, so the block synthesizes without internal tri-state logic. The A-to-B drive enable is active high and the B-to-A drive enable is active low. Every bit of a direction shares that direction's controls. The word width is a parameter with a default of 18.

The capture clock is an ordinary input. It is sampled on the system clock `clk`, and a rising edge is found by comparing two successive samples. The storage reset, `rst_n`, is active low and clears only the stored words.

Top module: `bxr_transceiver`

## Requirements
- R1: After reset both stored words are zero: with both latch enables low and both drives enabled, `b_out` and `a_out` read 0 whatever the source ports carry.
- R2: While `lat_en_ab` is 1, `b_out` equals `a_in` in the same cycle, with no edge of `clk` or `cap_ck_ab` needed.
- R3: At every `clk` edge where `lat_en_ab` is sampled 1, the A-to-B store loads `a_in`. After `lat_en_ab` falls, `b_out` keeps the `a_in` value sampled at the last such edge.
- R4: While `lat_en_ab` is 0 and `cap_ck_ab` stays constant (held low or held high), or falls, `b_out` does not change as `a_in` changes.
- R5: With `lat_en_ab` at 0, a `clk` edge where `cap_ck_ab` is sampled 1, after being sampled 0 at the previous edge, loads `a_in` into the store. `b_out` shows that value from that edge on. Reset treats the previous sample as 1, so a `cap_ck_ab` held high through reset captures nothing.
- R6: `b_oe` equals `drv_en_ab` (1 = drive, 0 = high impedance), and `b_out` reads 0 while `b_oe` is 0. Reset does not change this gating.
- R7: The B-to-A direction follows R2 to R5 with `lat_en_ba`, `cap_ck_ba`, `b_in` and `a_out`. Its drive enable `drv_en_ba_n` is active low: `a_oe` = 1 and `a_out` is driven when it is 0, and `a_oe` = 0 with `a_out` = 0 when it is 1.
- R8: The two directions are independent. No change on one direction's controls or source port alters the other direction's output.
- R9: When the same `clk` edge sees a rising capture clock and a high latch enable, the store loads the source word once. When a latch enable is 1 at one edge and 0 at the next, and the capture clock rises at that next edge, the store captures the source word present at that next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all controls |
| rst_n | input | 1 | Active-low reset of the stored words |
| a_in | input | W | Data arriving on port A |
| a_out | output | W | Data driven onto port A (0 when not driven) |
| a_oe | output | 1 | Port A drive enable (1 = drive, 0 = high impedance) |
| b_in | input | W | Data arriving on port B |
| b_out | output | W | Data driven onto port B (0 when not driven) |
| b_oe | output | 1 | Port B drive enable (1 = drive, 0 = high impedance) |
| lat_en_ab | input | 1 | A-to-B transparency control, active high |
| cap_ck_ab | input | 1 | A-to-B capture clock, rising edge captures |
| drv_en_ab | input | 1 | A-to-B drive enable onto port B, active high |
| lat_en_ba | input | 1 | B-to-A transparency control, active high |
| cap_ck_ba | input | 1 | B-to-A capture clock, rising edge captures |
| drv_en_ba_n | input | 1 | B-to-A drive enable onto port A, active low |

## Verification
Two functions can fall on the same `clk` edge: closing the latch and capturing on a rising capture clock. The bench creates this by raising the capture clock at the edge where the latch enable is still high. In another case it lowers the latch enable at the same moment it raises the capture clock. In the first case the word present at that edge must be stored exactly once and must still be shown after the latch closes. In the second case the output must keep the old transparent value until the edge and show the new word right after it. Both directions are also run together to show that neither one disturbs the other.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

    localparam int unsigned BXR_DEFAULT_W = 18;
    localparam int unsigned BXR_NUM_DIR   = 2;

    // Operation chosen for a storage element at a system clock edge
    typedef enum logic [1:0] {
        BXR_HOLD    = 2'd0,
        BXR_PASS    = 2'd1,
        BXR_CAPTURE = 2'd2
    } bxr_mode_e;

endpackage

// File: rtl/bxr_mode_sel.sv
module bxr_mode_sel
    import bxr_pkg::*;
(
    input  logic      lat_en,
    input  logic      cap_ck,
    input  logic      cap_ck_prev,
    output bxr_mode_e mode
);

    logic ck_rise;

    assign ck_rise = cap_ck & ~cap_ck_prev;

    // Transparency has priority; an edge while transparent loads the same word
    always_comb begin
        if (lat_en) begin
            mode = BXR_PASS;
        end else if (ck_rise) begin
            mode = BXR_CAPTURE;
        end else begin
            mode = BXR_HOLD;
        end
    end

endmodule

// File: rtl/bxr_store.sv
module bxr_store
    import bxr_pkg::*;
#(
    parameter int unsigned W = BXR_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lat_en,
    input  logic         cap_ck,
    input  logic [W-1:0] src,
    output logic [W-1:0] held
);

    typedef struct packed {
        logic [W-1:0] word;
        logic         ck_prev;
    } store_t;

    store_t    st_d;
    store_t    st_q;
    bxr_mode_e mode;

    bxr_mode_sel u_mode (
        .lat_en      (lat_en),
        .cap_ck      (cap_ck),
        .cap_ck_prev (st_q.ck_prev),
        .mode        (mode)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ck_prev = cap_ck;
        case (mode)
            BXR_PASS:    st_d.word = src;
            BXR_CAPTURE: st_d.word = src;
            default:     st_d.word = st_q.word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word    <= '0;
            st_q.ck_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign held = st_q.word;

endmodule

// File: rtl/bxr_drive.sv
module bxr_drive #(
    parameter int unsigned W          = 18,
    parameter bit          EN_ACT_LOW = 1'b0
) (
    input  logic         lat_en,
    input  logic [W-1:0] src,
    input  logic [W-1:0] held,
    input  logic         en_raw,
    output logic [W-1:0] dout,
    output logic         doe
);

    logic         en;
    logic [W-1:0] sel;

    generate
        if (EN_ACT_LOW) begin : g_low
            assign en = ~en_raw;
        end else begin : g_high
            assign en = en_raw;
        end
    endgenerate

    always_comb begin
        sel  = lat_en ? src : held;
        dout = en ? sel : '0;
        doe  = en;
    end

endmodule

// File: rtl/bxr_transceiver.sv
module bxr_transceiver
    import bxr_pkg::*;
#(
    parameter int unsigned W = BXR_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         lat_en_ab,
    input  logic         cap_ck_ab,
    input  logic         drv_en_ab,
    input  logic         lat_en_ba,
    input  logic         cap_ck_ba,
    input  logic         drv_en_ba_n
);

    localparam int unsigned ND = BXR_NUM_DIR;

    // Index 0 carries A to B, index 1 carries B to A
    logic [W-1:0] src   [ND];
    logic [W-1:0] held  [ND];
    logic [W-1:0] dout  [ND];
    logic         le    [ND];
    logic         ck    [ND];
    logic         en    [ND];
    logic         doe   [ND];

    assign src[0] = a_in;
    assign le[0]  = lat_en_ab;
    assign ck[0]  = cap_ck_ab;
    assign en[0]  = drv_en_ab;
    assign src[1] = b_in;
    assign le[1]  = lat_en_ba;
    assign ck[1]  = cap_ck_ba;
    assign en[1]  = drv_en_ba_n;

    generate
        for (genvar d = 0; d < ND; d++) begin : g_dir
            bxr_store #(.W(W)) u_store (
                .clk    (clk),
                .rst_n  (rst_n),
                .lat_en (le[d]),
                .cap_ck (ck[d]),
                .src    (src[d]),
                .held   (held[d])
            );

            bxr_drive #(.W(W), .EN_ACT_LOW(d == 1)) u_drive (
                .lat_en (le[d]),
                .src    (src[d]),
                .held   (held[d]),
                .en_raw (en[d]),
                .dout   (dout[d]),
                .doe    (doe[d])
            );
        end
    endgenerate

    assign b_out = dout[0];
    assign b_oe  = doe[0];
    assign a_out = dout[1];
    assign a_oe  = doe[1];

endmodule

// File: rtl/bxr_checker.sv
module bxr_checker #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         lat_en_ab,
    input logic         cap_ck_ab,
    input logic         drv_en_ab,
    input logic         lat_en_ba,
    input logic         cap_ck_ba,
    input logic         drv_en_ba_n
);

    // Two edges since reset before any two-deep history is trusted
    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= 2'd0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    // R2: transparent path
    a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_en_ab && drv_en_ab) |-> (b_out == a_in));

    // R3: value kept after latch enable falls
    a_r3_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0 && $past(lat_en_ab) && !lat_en_ab && drv_en_ab)
        |-> (b_out == $past(a_in)));

    // R4: no change with latch closed and no capture edge
    a_r4_static_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (warm[1] && !lat_en_ab && !$past(lat_en_ab)
         && !($past(cap_ck_ab) && !$past(cap_ck_ab, 2))
         && drv_en_ab && $past(drv_en_ab))
        |-> $stable(b_out));

    // R5: rising capture clock loads the source word
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (warm[1] && !lat_en_ab && !$past(lat_en_ab)
         && $past(cap_ck_ab) && !$past(cap_ck_ab, 2) && drv_en_ab)
        |-> (b_out == $past(a_in)));

    // R6: port B drive gating
    a_r6_b_gate: assert property (@(posedge clk)
        (b_oe == drv_en_ab) && (drv_en_ab || (b_out == '0)));

    // R7: port A drive gating, active-low enable
    a_r7_a_gate: assert property (@(posedge clk)
        (a_oe == !drv_en_ba_n) && (!drv_en_ba_n || (a_out == '0)));

    // R7: reverse direction transparency
    a_r7_ba_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_en_ba && !drv_en_ba_n) |-> (a_out == b_in));

    // R8: reverse output ignores forward controls while its own are idle
    a_r8_independent: assert property (@(posedge clk) disable iff (!rst_n)
        (warm[1] && !lat_en_ba && !$past(lat_en_ba)
         && !($past(cap_ck_ba) && !$past(cap_ck_ba, 2))
         && !drv_en_ba_n && !$past(drv_en_ba_n))
        |-> $stable(a_out));

endmodule

bind bxr_transceiver bxr_checker #(.W(W)) u_bxr_checker (.*);

// File: tb/tb_bxr_transceiver.sv
module tb_bxr_transceiver;

    localparam int unsigned W = 18;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe;
    logic         lat_en_ab, cap_ck_ab, drv_en_ab;
    logic         lat_en_ba, cap_ck_ba, drv_en_ba_n;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    bxr_transceiver #(.W(W)) dut (.*);

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One system clock edge; returns at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        a_in = 18'h2A5A5; b_in = 18'h15A5A;
        lat_en_ab = 0; cap_ck_ab = 1; drv_en_ab = 1;
        lat_en_ba = 0; cap_ck_ba = 1; drv_en_ba_n = 0;
        step(); step();
        settle();
        chk("R6 b_oe during reset", {17'd0, b_oe}, 18'd1);
        rst_n = 1'b1;
        step(); step();
        settle();
        chk("R1 b_out after reset", b_out, '0);
        chk("R1 a_out after reset", a_out, '0);
        chk("R5 held-high ck_ab captures nothing", b_out, '0);
        chk("R5 held-high ck_ba captures nothing", a_out, '0);
        cap_ck_ab = 0; cap_ck_ba = 0;
        step();
    endtask

    task automatic t_transparent();
        lat_en_ab = 1; a_in = 18'h00F0F;
        settle();
        chk("R2 follow 1", b_out, 18'h00F0F);
        a_in = 18'h3C3C3;
        settle();
        chk("R2 follow 2 no edge", b_out, 18'h3C3C3);
    endtask

    task automatic t_hold_fall();
        lat_en_ab = 1; a_in = 18'h12345;
        step();
        lat_en_ab = 0; a_in = 18'h0BEEF;
        settle();
        chk("R3 kept after fall", b_out, 18'h12345);
        step();
        chk("R3 kept next cycle", b_out, 18'h12345);
    endtask

    task automatic t_static_clock();
        cap_ck_ab = 0; a_in = 18'h11111;
        step();
        a_in = 18'h22222;
        step();
        chk("R4 ck held low", b_out, 18'h12345);
        cap_ck_ab = 1; a_in = 18'h33333;
        step();
        chk("R5 rise captures", b_out, 18'h33333);
        a_in = 18'h04444;
        step(); step();
        chk("R4 ck held high", b_out, 18'h33333);
        cap_ck_ab = 0; a_in = 18'h05555;
        step();
        chk("R4 falling ck no capture", b_out, 18'h33333);
    endtask

    task automatic t_capture();
        a_in = 18'h2AAAA; cap_ck_ab = 1;
        settle();
        chk("R5 before edge", b_out, 18'h33333);
        step();
        chk("R5 after edge", b_out, 18'h2AAAA);
        cap_ck_ab = 0;
        step();
    endtask

    task automatic t_oe();
        drv_en_ab = 0;
        settle();
        chk("R6 b_oe off", {17'd0, b_oe}, 18'd0);
        chk("R6 b_out zero off", b_out, '0);
        lat_en_ab = 1;
        settle();
        chk("R6 zero even transparent", b_out, '0);
        lat_en_ab = 0; drv_en_ab = 1;
        settle();
        chk("R6 b_oe on", {17'd0, b_oe}, 18'd1);
        chk("R6 stored word back", b_out, a_in);
    endtask

    task automatic t_ba();
        lat_en_ba = 1; b_in = 18'h0ACE1;
        settle();
        chk("R7 ba transparent", a_out, 18'h0ACE1);
        step();
        lat_en_ba = 0; b_in = 18'h01111;
        settle();
        chk("R7 ba hold", a_out, 18'h0ACE1);
        cap_ck_ba = 1;
        step();
        chk("R7 ba capture", a_out, 18'h01111);
        cap_ck_ba = 0;
        drv_en_ba_n = 1;
        settle();
        chk("R7 a_oe off", {17'd0, a_oe}, 18'd0);
        chk("R7 a_out zero off", a_out, '0);
        drv_en_ba_n = 0;
        step();
    endtask

    task automatic t_independent();
        b_in = 18'h3FFFF;
        lat_en_ab = 1; a_in = 18'h15555;
        step();
        cap_ck_ab = 1; lat_en_ab = 0;
        step();
        drv_en_ab = 0;
        settle();
        chk("R8 a_out untouched", a_out, 18'h01111);
        drv_en_ab = 1; cap_ck_ab = 0;
        lat_en_ba = 1;
        step();
        lat_en_ba = 0; cap_ck_ba = 1; b_in = 18'h00007;
        step();
        chk("R8 b_out untouched", b_out, 18'h15555);
        cap_ck_ba = 0;
        step();
    endtask

    task automatic t_same_edge();
        lat_en_ab = 1; cap_ck_ab = 0; a_in = 18'h01234;
        step();
        cap_ck_ab = 1; a_in = 18'h0A0A0;
        step();
        lat_en_ab = 0; a_in = 18'h0F00F;
        settle();
        chk("R9 rise with latch open stores once", b_out, 18'h0A0A0);
        cap_ck_ab = 0;
        step();
        chk("R9 no second load", b_out, 18'h0A0A0);
        lat_en_ab = 1; a_in = 18'h06060;
        step();
        lat_en_ab = 0; cap_ck_ab = 1; a_in = 18'h09090;
        settle();
        chk("R9 before closing edge", b_out, 18'h06060);
        step();
        chk("R9 close and rise capture", b_out, 18'h09090);
        cap_ck_ab = 0;
        step();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_cmp++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_transparent();
        t_hold_fall();
        t_static_clock();
        t_capture();
        t_oe();
        t_ba();
        t_independent();
        t_same_edge();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule